// File: doc/BRIEF.md
# Parallel Port with Edge-Triggered Interrupts

This block provides two 8-bit general-purpose ports, A and B. Each bit of each port can be an input or an output, chosen by a direction register. Each port also has two control inputs. When the chosen edge arrives on the first control line of a port, it raises an interrupt flag. It can also freeze the port's input pins into a latch, so that a later read returns the value present at that event. An edge on the second control line raises its own flag, with a selectable polarity.

The block owns the interrupt flag register and the interrupt enable register. Besides its own four edge sources, it accepts one-cycle flag-set pulses from a neighbouring shift register and from two timers. All enabled and set flags are combined into one active-low interrupt output.

A processor accesses the block through an 8-bit register interface with a 4-bit select and single-cycle read and write strobes. Reads return data combinationally. Accessing port A at one select clears that port's control-line flags. A second select reaches the same port A register and leaves the flags unchanged.

Top module: `pio_edge_port`

## Requirements
- R1: After reset, every register reads zero except the enable register, whose bit 7 reads 1. Both output-enable buses are 0, so all pins are inputs. `irq_n` is high.
- R2: Register selects are as follows: 0 is port B data, 1 is port A data, 2 is port B direction, 3 is port A direction, 11 is auxiliary control, 12 is peripheral control, 13 is the flag register, 14 is the enable register and 15 is port A data without flag clearing. Any other select reads 0 and ignores writes.
- R3: For each bit, a direction value of 1 makes the pin an output and 0 makes it an input. `pa_pin_oe` and `pb_pin_oe` show the direction registers, and `pa_pin_out` and `pb_pin_out` show the written output registers.
- R4: A port data read returns the output register on output bits and the pin value on input bits.
- R5: Peripheral control bit 0 (port A) and bit 4 (port B) select the active edge of the first control line: 0 means falling and 1 means rising. The active edge sets flag 1 (CA1) or flag 4 (CB1) within four clocks, after a two-flop synchronizer. The other edge has no effect.
- R6: Peripheral control bit 2 (port A) and bit 6 (port B) select the active edge of the second control line: 0 means falling and 1 means rising. The active edge sets flag 0 (CA2) or flag 3 (CB2).
- R7: When auxiliary control bit 0 (port A) or bit 1 (port B) is set, the active first-control-line edge captures the port pins. Input bits then read the captured value, not the live pins.
- R8: Writing the flag register clears each flag whose data bit is 1 and leaves the others unchanged. Flag register bit 7 reads 1 exactly when some flag and its enable bit are both set.
- R9: A write to the enable register with data bit 7 set sets the enable bits marked by 1s. With data bit 7 clear, it clears those bits. Reading the enable register returns bit 7 as 1.
- R10: `irq_n` is low exactly when some flag and its enable bit are both set.
- R11: A read or write at select 1 clears flags 0 and 1. A read or write at select 0 clears flags 3 and 4. Select 15 leaves all flags unchanged.
- R12: `sr_flag_set` sets flag 2, `t2_flag_set` sets flag 5 and `t1_flag_set` sets flag 6. A set pulse or edge wins over a clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 4 | Register select |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle (drives read side effects) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_sel` |
| pa_pin_in | input | 8 | Port A pin levels |
| pa_pin_out | output | 8 | Port A output register |
| pa_pin_oe | output | 8 | Port A output enables (direction) |
| pb_pin_in | input | 8 | Port B pin levels |
| pb_pin_out | output | 8 | Port B output register |
| pb_pin_oe | output | 8 | Port B output enables (direction) |
| ca1_in | input | 1 | Port A first control line |
| ca2_in | input | 1 | Port A second control line |
| cb1_in | input | 1 | Port B first control line |
| cb2_in | input | 1 | Port B second control line |
| sr_flag_set | input | 1 | Shift-register flag set pulse |
| t2_flag_set | input | 1 | Timer 2 flag set pulse |
| t1_flag_set | input | 1 | Timer 1 flag set pulse |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
Port reads use pin patterns whose nibbles differ from the output register. A swapped direction mask therefore shows up as a wrong nibble. Every control line is driven through both its inactive and its active edge, so a wrong polarity bit or a level-sensitive detector sets a flag at the wrong step. The pins change after a capture edge, which tells a working latch apart from a live read. The same flags are then cleared through select 1, select 0, select 15 and a flag-register write whose data holds both zeros and ones. This separates the clearing paths from one another and a clear from a set that arrives in the same cycle.

// File: rtl/pio_pkg.sv
package pio_pkg;
   // register select codes
   localparam logic [3:0] SEL_PB_DATA  = 4'd0;
   localparam logic [3:0] SEL_PA_DATA  = 4'd1;
   localparam logic [3:0] SEL_PB_DIR   = 4'd2;
   localparam logic [3:0] SEL_PA_DIR   = 4'd3;
   localparam logic [3:0] SEL_AUX_CTL  = 4'd11;
   localparam logic [3:0] SEL_PER_CTL  = 4'd12;
   localparam logic [3:0] SEL_FLAGS    = 4'd13;
   localparam logic [3:0] SEL_ENABLES  = 4'd14;
   localparam logic [3:0] SEL_PA_QUIET = 4'd15;

   // flag bit positions
   localparam int FLG_CA2 = 0;
   localparam int FLG_CA1 = 1;
   localparam int FLG_SR  = 2;
   localparam int FLG_CB2 = 3;
   localparam int FLG_CB1 = 4;
   localparam int FLG_T2  = 5;
   localparam int FLG_T1  = 6;

   // control line index inside the synchronizer array
   localparam int LN_CA1 = 0;
   localparam int LN_CA2 = 1;
   localparam int LN_CB1 = 2;
   localparam int LN_CB2 = 3;
   localparam int NUM_LINES = 4;
endpackage

// File: rtl/pio_edge_sync.sv
module pio_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_in,
   input  logic rise_sel,
   output logic edge_o
);
   localparam int PIPE_W = STAGES + 1;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pio_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [PIPE_W-1:0] pipe_q;
   logic now_lvl;
   logic old_lvl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= '0;
      else        pipe_q <= {pipe_q[PIPE_W-2:0], line_in};
   end

   assign now_lvl = pipe_q[STAGES-1];
   assign old_lvl = pipe_q[STAGES];
   assign edge_o  = rise_sel ? (now_lvl & ~old_lvl) : (~now_lvl & old_lvl);

   // R5
   no_double_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_o && $stable(rise_sel)) |=> !edge_o);
endmodule

// File: rtl/pio_port.sv
module pio_port #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         data_we,
   input  logic         dir_we,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] pins_in,
   input  logic         latch_en,
   input  logic         strobe_edge,
   output logic [W-1:0] out_q,
   output logic [W-1:0] dir_q,
   output logic [W-1:0] rdata
);
   logic [W-1:0] latch_q;
   logic [W-1:0] in_view;
   logic         capture;

   assign capture = strobe_edge & latch_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q   <= '0;
         dir_q   <= '0;
         latch_q <= '0;
      end else begin
         if (data_we) out_q   <= wdata;
         if (dir_we)  dir_q   <= wdata;
         if (capture) latch_q <= pins_in;
      end
   end

   assign in_view = latch_en ? latch_q : pins_in;

   generate
      for (genvar b = 0; b < W; b++) begin : g_bit
         assign rdata[b] = dir_q[b] ? out_q[b] : in_view[b];
      end
   endgenerate

   // R7
   latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !capture |=> $stable(latch_q));
endmodule

// File: rtl/pio_irq_ctl.sv
module pio_irq_ctl #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-2:0] set_vec,
   input  logic [DATA_W-2:0] clr_vec,
   input  logic              flag_we,
   input  logic              en_we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-2:0] flag_q,
   output logic [DATA_W-2:0] en_q,
   output logic              irq_any
);
   localparam int NF = DATA_W - 1;

   logic [NF-1:0] clr_all;
   logic [NF-1:0] flag_d;
   logic [NF-1:0] en_d;

   always_comb begin
      clr_all = clr_vec | (flag_we ? wdata[NF-1:0] : '0);
      flag_d  = (flag_q & ~clr_all) | set_vec;
      en_d    = en_q;
      if (en_we) begin
         if (wdata[DATA_W-1]) en_d = en_q | wdata[NF-1:0];
         else                 en_d = en_q & ~wdata[NF-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= '0;
         en_q   <= '0;
      end else begin
         flag_q <= flag_d;
         en_q   <= en_d;
      end
   end

   assign irq_any = |(flag_q & en_q);

   generate
      for (genvar i = 0; i < NF; i++) begin : g_chk
         // R8
         flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_we && wdata[i] && !set_vec[i]) |=> !flag_q[i]);
         // R12
         set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[i] |=> flag_q[i]);
         // R9
         en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (en_we && !wdata[DATA_W-1] && wdata[i]) |=> !en_q[i]);
      end
   endgenerate
endmodule

// File: rtl/pio_edge_port.sv
module pio_edge_port
   import pio_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        bus_sel,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [DATA_W-1:0] pa_pin_in,
   output logic [DATA_W-1:0] pa_pin_out,
   output logic [DATA_W-1:0] pa_pin_oe,
   input  logic [DATA_W-1:0] pb_pin_in,
   output logic [DATA_W-1:0] pb_pin_out,
   output logic [DATA_W-1:0] pb_pin_oe,
   input  logic              ca1_in,
   input  logic              ca2_in,
   input  logic              cb1_in,
   input  logic              cb2_in,
   input  logic              sr_flag_set,
   input  logic              t2_flag_set,
   input  logic              t1_flag_set,
   output logic              irq_n
);
   localparam int NF = DATA_W - 1;

   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("pio_edge_port: register layout needs DATA_W of 8");
      end
   endgenerate

   logic [DATA_W-1:0]    aux_q;
   logic [DATA_W-1:0]    pctl_q;
   logic [NUM_LINES-1:0] line_in;
   logic [NUM_LINES-1:0] line_pol;
   logic [NUM_LINES-1:0] line_edge;
   logic [DATA_W-1:0]    pa_rdata;
   logic [DATA_W-1:0]    pb_rdata;
   logic [NF-1:0]        set_vec;
   logic [NF-1:0]        clr_vec;
   logic [NF-1:0]        flag_q;
   logic [NF-1:0]        en_q;
   logic                 irq_any;
   logic                 acc;
   logic                 pa_touch;
   logic                 pb_touch;

   assign acc      = bus_wr | bus_rd;
   assign pa_touch = acc && (bus_sel == SEL_PA_DATA);
   assign pb_touch = acc && (bus_sel == SEL_PB_DATA);

   // control-line synchronizers and edge detectors
   assign line_in[LN_CA1]  = ca1_in;
   assign line_in[LN_CA2]  = ca2_in;
   assign line_in[LN_CB1]  = cb1_in;
   assign line_in[LN_CB2]  = cb2_in;
   assign line_pol[LN_CA1] = pctl_q[0];
   assign line_pol[LN_CA2] = pctl_q[2];
   assign line_pol[LN_CB1] = pctl_q[4];
   assign line_pol[LN_CB2] = pctl_q[6];

   generate
      for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
         pio_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .line_in  (line_in[k]),
            .rise_sel (line_pol[k]),
            .edge_o   (line_edge[k])
         );
      end
   endgenerate

   // control registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         aux_q  <= '0;
         pctl_q <= '0;
      end else if (bus_wr) begin
         if (bus_sel == SEL_AUX_CTL) aux_q  <= bus_wdata;
         if (bus_sel == SEL_PER_CTL) pctl_q <= bus_wdata;
      end
   end

   pio_port #(.W(DATA_W)) i_port_a (
      .clk         (clk),
      .rst_n       (rst_n),
      .data_we     (bus_wr && (bus_sel == SEL_PA_DATA || bus_sel == SEL_PA_QUIET)),
      .dir_we      (bus_wr && (bus_sel == SEL_PA_DIR)),
      .wdata       (bus_wdata),
      .pins_in     (pa_pin_in),
      .latch_en    (aux_q[0]),
      .strobe_edge (line_edge[LN_CA1]),
      .out_q       (pa_pin_out),
      .dir_q       (pa_pin_oe),
      .rdata       (pa_rdata)
   );

   pio_port #(.W(DATA_W)) i_port_b (
      .clk         (clk),
      .rst_n       (rst_n),
      .data_we     (bus_wr && (bus_sel == SEL_PB_DATA)),
      .dir_we      (bus_wr && (bus_sel == SEL_PB_DIR)),
      .wdata       (bus_wdata),
      .pins_in     (pb_pin_in),
      .latch_en    (aux_q[1]),
      .strobe_edge (line_edge[LN_CB1]),
      .out_q       (pb_pin_out),
      .dir_q       (pb_pin_oe),
      .rdata       (pb_rdata)
   );

   // flag sources and port-access clears
   always_comb begin
      set_vec          = '0;
      set_vec[FLG_CA2] = line_edge[LN_CA2];
      set_vec[FLG_CA1] = line_edge[LN_CA1];
      set_vec[FLG_SR]  = sr_flag_set;
      set_vec[FLG_CB2] = line_edge[LN_CB2];
      set_vec[FLG_CB1] = line_edge[LN_CB1];
      set_vec[FLG_T2]  = t2_flag_set;
      set_vec[FLG_T1]  = t1_flag_set;
      clr_vec          = '0;
      clr_vec[FLG_CA2] = pa_touch;
      clr_vec[FLG_CA1] = pa_touch;
      clr_vec[FLG_CB2] = pb_touch;
      clr_vec[FLG_CB1] = pb_touch;
   end

   pio_irq_ctl #(.DATA_W(DATA_W)) i_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vec (set_vec),
      .clr_vec (clr_vec),
      .flag_we (bus_wr && (bus_sel == SEL_FLAGS)),
      .en_we   (bus_wr && (bus_sel == SEL_ENABLES)),
      .wdata   (bus_wdata),
      .flag_q  (flag_q),
      .en_q    (en_q),
      .irq_any (irq_any)
   );

   assign irq_n = ~irq_any;

   // read multiplexer
   always_comb begin
      unique case (bus_sel)
         SEL_PB_DATA:               bus_rdata = pb_rdata;
         SEL_PA_DATA, SEL_PA_QUIET: bus_rdata = pa_rdata;
         SEL_PB_DIR:                bus_rdata = pb_pin_oe;
         SEL_PA_DIR:                bus_rdata = pa_pin_oe;
         SEL_AUX_CTL:               bus_rdata = aux_q;
         SEL_PER_CTL:               bus_rdata = pctl_q;
         SEL_FLAGS:                 bus_rdata = {irq_any, flag_q};
         SEL_ENABLES:               bus_rdata = {1'b1, en_q};
         default:                   bus_rdata = '0;
      endcase
   end

   // R11
   quiet_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && bus_sel == SEL_PA_QUIET && flag_q[FLG_CA1]) |=> flag_q[FLG_CA1]);
   // R11
   pa_touch_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pa_touch && !line_edge[LN_CA1]) |=> !flag_q[FLG_CA1]);
   // R10
   irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_n) |-> (bus_sel != SEL_FLAGS || bus_rdata[DATA_W-1]));
endmodule

// File: tb/test_pio_edge_port.sv
`timescale 1ns/100ps
module test_pio_edge_port;
   localparam real HALF = 2.5;
   localparam int  NV   = 62;
   // op: 0 write, 1 read+compare, 2 port A pins, 3 port B pins,
   //     4 control lines {cb2,cb1,ca2,ca1} then settle, 5 irq_n check, 6 set pulses {t1,t2,sr}
   localparam logic [31:0] VEC [NV] = '{
      {4'd1, 4'd2,  8'h00, 8'h00, 8'd1},   // R1
      {4'd1, 4'd13, 8'h00, 8'h00, 8'd1},   // R1
      {4'd1, 4'd14, 8'h00, 8'h80, 8'd9},   // R9
      {4'd0, 4'd3,  8'hF0, 8'h00, 8'd3},
      {4'd0, 4'd1,  8'hA5, 8'h00, 8'd3},
      {4'd2, 4'd0,  8'h3C, 8'h00, 8'd4},
      {4'd1, 4'd1,  8'h00, 8'hAC, 8'd4},   // R4
      {4'd1, 4'd3,  8'h00, 8'hF0, 8'd2},   // R2
      {4'd0, 4'd2,  8'h0F, 8'h00, 8'd3},
      {4'd0, 4'd0,  8'h5A, 8'h00, 8'd3},
      {4'd3, 4'd0,  8'hC3, 8'h00, 8'd4},
      {4'd1, 4'd0,  8'h00, 8'hCA, 8'd4},   // R4
      {4'd0, 4'd12, 8'h01, 8'h00, 8'd5},
      {4'd4, 4'd0,  8'h01, 8'h00, 8'd5},
      {4'd1, 4'd13, 8'h00, 8'h02, 8'd5},   // R5
      {4'd0, 4'd14, 8'h82, 8'h00, 8'd9},
      {4'd1, 4'd13, 8'h00, 8'h82, 8'd8},   // R8
      {4'd5, 4'd0,  8'h00, 8'h00, 8'd10},  // R10
      {4'd1, 4'd15, 8'h00, 8'hAC, 8'd11},  // R11
      {4'd1, 4'd13, 8'h00, 8'h82, 8'd11},  // R11
      {4'd1, 4'd1,  8'h00, 8'hAC, 8'd11},
      {4'd1, 4'd13, 8'h00, 8'h00, 8'd11},  // R11
      {4'd5, 4'd0,  8'h00, 8'h01, 8'd10},  // R10
      {4'd4, 4'd0,  8'h00, 8'h00, 8'd5},
      {4'd1, 4'd13, 8'h00, 8'h00, 8'd5},   // R5
      {4'd4, 4'd0,  8'h02, 8'h00, 8'd6},
      {4'd1, 4'd13, 8'h00, 8'h00, 8'd6},   // R6
      {4'd4, 4'd0,  8'h00, 8'h00, 8'd6},
      {4'd1, 4'd13, 8'h00, 8'h01, 8'd6},   // R6
      {4'd0, 4'd13, 8'h00, 8'h00, 8'd8},
      {4'd1, 4'd13, 8'h00, 8'h01, 8'd8},   // R8
      {4'd0, 4'd13, 8'h01, 8'h00, 8'd8},
      {4'd1, 4'd13, 8'h00, 8'h00, 8'd8},   // R8
      {4'd4, 4'd0,  8'h04, 8'h00, 8'd5},
      {4'd1, 4'd13, 8'h00, 8'h00, 8'd5},   // R5
      {4'd4, 4'd0,  8'h00, 8'h00, 8'd5},
      {4'd1, 4'd13, 8'h00, 8'h10, 8'd5},   // R5
      {4'd0, 4'd14, 8'h90, 8'h00, 8'd9},
      {4'd1, 4'd14, 8'h00, 8'h92, 8'd9},   // R9
      {4'd1, 4'd13, 8'h00, 8'h90, 8'd8},   // R8
      {4'd0, 4'd0,  8'h00, 8'h00, 8'd11},
      {4'd1, 4'd13, 8'h00, 8'h00, 8'd11},  // R11
      {4'd0, 4'd14, 8'h02, 8'h00, 8'd9},
      {4'd1, 4'd14, 8'h00, 8'h90, 8'd9},   // R9
      {4'd6, 4'd0,  8'h07, 8'h00, 8'd12},
      {4'd1, 4'd13, 8'h00, 8'h64, 8'd12},  // R12
      {4'd0, 4'd13, 8'h7F, 8'h00, 8'd8},
      {4'd1, 4'd13, 8'h00, 8'h00, 8'd8},   // R8
      {4'd0, 4'd11, 8'h01, 8'h00, 8'd7},
      {4'd2, 4'd0,  8'h0F, 8'h00, 8'd7},
      {4'd4, 4'd0,  8'h01, 8'h00, 8'd7},
      {4'd2, 4'd0,  8'h00, 8'h00, 8'd7},
      {4'd1, 4'd15, 8'h00, 8'hAF, 8'd7},   // R7
      {4'd0, 4'd11, 8'h00, 8'h00, 8'd7},
      {4'd1, 4'd15, 8'h00, 8'hA0, 8'd7},   // R7
      {4'd0, 4'd5,  8'hFF, 8'h00, 8'd2},
      {4'd1, 4'd5,  8'h00, 8'h00, 8'd2},   // R2
      {4'd1, 4'd12, 8'h00, 8'h01, 8'd2},   // R2
      {4'd1, 4'd11, 8'h00, 8'h00, 8'd2},   // R2
      {4'd0, 4'd12, 8'h41, 8'h00, 8'd6},
      {4'd4, 4'd0,  8'h09, 8'h00, 8'd6},
      {4'd1, 4'd13, 8'h00, 8'h0A, 8'd6}    // R6
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] bus_sel = '0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0, bus_rdata;
   logic [7:0] pa_pin_in = '0, pa_pin_out, pa_pin_oe;
   logic [7:0] pb_pin_in = '0, pb_pin_out, pb_pin_oe;
   logic       ca1_in = 1'b0, ca2_in = 1'b0, cb1_in = 1'b0, cb2_in = 1'b0;
   logic       sr_flag_set = 1'b0, t2_flag_set = 1'b0, t1_flag_set = 1'b0;
   logic       irq_n;
   int         n_vec = 0, n_bad = 0;

   always #(HALF) clk = ~clk;

   pio_edge_port i_pio_edge_port (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pa_pin_in(pa_pin_in), .pa_pin_out(pa_pin_out), .pa_pin_oe(pa_pin_oe),
      .pb_pin_in(pb_pin_in), .pb_pin_out(pb_pin_out), .pb_pin_oe(pb_pin_oe),
      .ca1_in(ca1_in), .ca2_in(ca2_in), .cb1_in(cb1_in), .cb2_in(cb2_in),
      .sr_flag_set(sr_flag_set), .t2_flag_set(t2_flag_set), .t1_flag_set(t1_flag_set),
      .irq_n(irq_n)
   );

   task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL R%0d: got %02h, expected %02h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic bus_write(input logic [3:0] sel, input logic [7:0] d);
      @(negedge clk);
      bus_sel = sel; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [3:0] sel, input logic [7:0] exp, input int req);
      @(negedge clk);
      bus_sel = sel; bus_rd = 1'b1;
      #1 check(req, bus_rdata, exp);
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   initial begin
      #(HALF * 2 * 150000);
      n_bad++;
      $display("FAIL watchdog: run did not finish, got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state at the pins
      check(1, pa_pin_oe, 8'h00);
      check(1, pb_pin_oe, 8'h00);
      check(1, {7'd0, irq_n}, 8'h01);

      for (int v = 0; v < NV; v++) begin
         logic [3:0] op, sel;
         logic [7:0] d, e, rq;
         {op, sel, d, e, rq} = VEC[v];
         case (op)
            4'd0: bus_write(sel, d);
            4'd1: bus_read(sel, e, int'(rq));
            4'd2: begin @(negedge clk); pa_pin_in = d; end
            4'd3: begin @(negedge clk); pb_pin_in = d; end
            4'd4: begin
               @(negedge clk);
               {cb2_in, cb1_in, ca2_in, ca1_in} = d[3:0];
               repeat (4) @(negedge clk);
            end
            4'd5: begin @(negedge clk); check(int'(rq), {7'd0, irq_n}, e); end
            default: begin
               @(negedge clk);
               {t1_flag_set, t2_flag_set, sr_flag_set} = d[2:0];
               @(negedge clk);
               {t1_flag_set, t2_flag_set, sr_flag_set} = 3'b000;
            end
         endcase
      end

      // R3 pin drive and direction
      check(3, pa_pin_oe, 8'hF0);
      check(3, pa_pin_out, 8'hA5);
      check(3, pb_pin_oe, 8'h0F);
      check(3, pb_pin_out, 8'h00);

      // R12 set beats simultaneous clear (flags 0x0A present)
      @(negedge clk);
      bus_sel = 4'd13; bus_wdata = 8'h40; bus_wr = 1'b1; t1_flag_set = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; t1_flag_set = 1'b0;
      bus_read(4'd13, 8'h4A, 12);

      // R1 reset in mid-run
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      bus_read(4'd13, 8'h00, 1);
      bus_read(4'd14, 8'h80, 1);
      bus_read(4'd12, 8'h00, 1);
      bus_read(4'd3,  8'h00, 1);
      check(1, {7'd0, irq_n}, 8'h01);
      check(1, pa_pin_oe, 8'h00);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule